// File: doc/BRIEF.md
# ADC Ramp Linearity Analyzer

This block measures the static linearity of an analog-to-digital converter from its own output words. The converter is driven by a slow, linear ramp that spans its whole input range, so an ideal part spends the same time in every code. The analyzer counts how often each output code appears over a record of a programmed length. After the record it turns the counts into a width error per code (DNL) and an accumulated transition error (INL), all in LSB with 8 fractional bits. It also keeps the largest absolute value of each.

Software or a test sequencer pulses `clear`, programs `rec_len`, pulses `start` and streams samples in with `smp_valid`. It then waits for `done` and reads any code through `rd_addr`. The two end codes take in any out-of-range input, so they are left out of the width arithmetic. Only codes bounded by two transitions set the ideal width.

Top module: `adc_ramp_linearity`

## Requirements
- R1: Each accepted sample adds one to the count of its code. `rd_count` returns the count of the code on `rd_addr` one clock after the address is applied.
- R2: A pulse of `start` while idle latches `rec_len` and opens a record. Exactly `rec_len` valid samples are counted. Samples before `start`, and samples after the record is full, change no count.
- R3: A count that has reached its all-ones value stays there. The sample that would have wrapped it sets `overflow`, which stays high until the next clear.
- R4: The ideal count per code is floor(S*256/(2^CODE_W-2)). S is the sum of the counts of codes 1 to 2^CODE_W-2.
- R5: For an inner code with count H>0, `rd_dnl` = floor(H*65536/ideal)-256, a signed value with 8 fractional bits. Code 0 and the full-scale code report a DNL of 0.
- R6: An inner code with a zero count is a missing code and reports a DNL of exactly -256 (-1 LSB).
- R7: `rd_inl` for code k is the sum of the DNL values of inner codes 1 to k-1, which is the error at the lower transition of code k. Code 0 reports 0. The full-scale code reports the sum over all inner codes.
- R8: `max_dnl` is the largest absolute DNL over the inner codes. `max_inl` is the largest absolute INL over all reported codes.
- R9: `done` rises once the analysis of a full record ends and holds until `clear`. A `start` or any samples while `done` is high change no count and leave `done` high.
- R10: A `clear` pulse drops `done`, `overflow` and both maxima at once. It zeroes every count over the next 2^CODE_W cycles, and a `start` is accepted from 2^CODE_W+2 cycles after the pulse.
- R11: After reset, `done` and `overflow` are low, both maxima read 0, and every count reads 0 once the same zeroing sweep has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero the histogram and results |
| start | input | 1 | Open a record while idle |
| rec_len | input | LEN_W | Number of samples in the record |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| rd_addr | input | CODE_W | Code to read back |
| rd_count | output | CNT_W | Count of the addressed code |
| rd_dnl | output | RES_W | Signed DNL of the addressed code, 8 fraction bits |
| rd_inl | output | RES_W | Signed INL at the lower transition of the addressed code |
| max_dnl | output | RES_W | Largest absolute inner DNL |
| max_inl | output | RES_W | Largest absolute INL |
| overflow | output | 1 | Sticky count saturation flag |
| done | output | 1 | Analysis complete |

## Verification
Some properties are checked on every cycle. The record counter never passes the latched length, `done` and `overflow` only fall on a clear, and the divider remainder stays below its divisor. Every computed DNL stays at or above -1 LSB, the end codes write a zero DNL, and the maxima never fall while an analysis runs. Whether the numbers are right needs the bench scenarios. These cover a uniform ramp with stray samples before and after the record, an uneven ramp with gaps and two missing codes, and a single code driven past saturation. In each one the bench recomputes every count, DNL, INL and maximum from the requirements and compares them through the read port.

// File: rtl/arl_pkg.sv
package arl_pkg;
  typedef enum logic [2:0] {
    T_CLR, T_IDLE, T_CAP, T_DRAIN, T_ANA, T_DONE
  } ctl_state_t;

  typedef enum logic [3:0] {
    E_IDLE, E_SUMA, E_SUMD, E_IDIV, E_IWAIT,
    E_BADDR, E_BDATA, E_BWAIT, E_BWRITE
  } eng_state_t;
endpackage

// File: rtl/arl_divider.sv
module arl_divider #(
  parameter int NUM_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W:0]   rem_q, trial;
  logic [NUM_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, ge;

  // restoring step: shift one numerator bit into the remainder
  always_comb begin
    trial = {rem_q[NUM_W-1:0], quot[NUM_W-1]};
    ge    = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done   <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quot   <= '0;
      den_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quot   <= num;
        den_q  <= den;
        rem_q  <= '0;
        cnt_q  <= CW'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? (trial - {1'b0, den_q}) : trial;
        quot  <= {quot[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R5: a finished division leaves a remainder below the divisor
  p_div_rem_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/arl_bin_store.sv
module arl_bin_store #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  output logic              clr_busy,
  input  logic              acc_v,
  input  logic [CODE_W-1:0] acc_code,
  input  logic              eng_sel,
  input  logic [CODE_W-1:0] eng_addr,
  input  logic [CODE_W-1:0] usr_addr,
  output logic [CNT_W-1:0]  q,
  output logic              ovf
);
  localparam int NCODE = 1 << CODE_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  mem [NCODE];
  logic [CODE_W-1:0] cidx;
  logic              p1_v, wl_v;
  logic [CODE_W-1:0] p1_c, wl_c;
  logic [CNT_W-1:0]  wl_d, base, inc;
  logic              sat, we;
  logic [CODE_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  wdata;

  // zeroing sweep, also started by reset
  always_ff @(posedge clk) begin
    if (rst || clr_req) begin
      clr_busy <= 1'b1;
      cidx     <= '0;
    end else if (clr_busy) begin
      cidx <= cidx + 1'b1;
      if (cidx == CODE_W'(NCODE - 1)) clr_busy <= 1'b0;
    end
  end

  // read-modify-write pipeline: read at stage 0, write at stage 1
  always_ff @(posedge clk) begin
    if (rst || clr_req || clr_busy) begin
      p1_v <= 1'b0;
      p1_c <= '0;
      wl_v <= 1'b0;
      wl_c <= '0;
      wl_d <= '0;
    end else begin
      p1_v <= acc_v;
      p1_c <= acc_code;
      wl_v <= p1_v;
      wl_c <= p1_c;
      wl_d <= inc;
    end
  end

  always_comb begin
    // the read of the previous write's address returned the old value
    base  = (wl_v && (wl_c == p1_c)) ? wl_d : q;
    sat   = (base == CMAX);
    inc   = sat ? base : base + 1'b1;
    we    = clr_busy || p1_v;
    waddr = clr_busy ? cidx : p1_c;
    wdata = clr_busy ? '0 : inc;
    if (acc_v)        raddr = acc_code;
    else if (eng_sel) raddr = eng_addr;
    else              raddr = usr_addr;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_req)  ovf <= 1'b0;
    else if (p1_v && sat) ovf <= 1'b1;
  end

  // R3: saturation flag is sticky until a clear
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_req) |=> ovf);
endmodule

// File: rtl/arl_engine.sv
module arl_engine #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12,
  parameter int FRAC   = 8,
  localparam int NUM_A = CNT_W + 2 * FRAC,
  localparam int NUM_B = CNT_W + CODE_W + FRAC,
  localparam int NUM_W = (NUM_A > NUM_B) ? NUM_A : NUM_B,
  localparam int RES_W = NUM_W + CODE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    go,
  input  logic [CNT_W-1:0]        cnt_q,
  output logic                    eng_sel,
  output logic [CODE_W-1:0]       eng_addr,
  output logic                    fin,
  input  logic [CODE_W-1:0]       usr_addr,
  output logic signed [RES_W-1:0] rd_dnl,
  output logic signed [RES_W-1:0] rd_inl,
  output logic [RES_W-1:0]        max_dnl,
  output logic [RES_W-1:0]        max_inl
);
  import arl_pkg::*;

  localparam int NCODE  = 1 << CODE_W;
  localparam int NINNER = NCODE - 2;
  localparam int SUM_W  = CNT_W + CODE_W;
  localparam logic signed [RES_W-1:0] ONE_S   = RES_W'(1 << FRAC);
  localparam logic signed [RES_W-1:0] NEG_ONE = -ONE_S;

  eng_state_t               st;
  logic [CODE_W-1:0]        idx;
  logic [SUM_W-1:0]         sum_q;
  logic [NUM_W-1:0]         ideal_q, div_num, div_den, div_q;
  logic                     div_go, div_done, inner, res_we;
  logic signed [RES_W-1:0]  dnl_cur, acc;
  logic [2*RES_W-1:0]       res_mem [NCODE];
  logic [2*RES_W-1:0]       rq;

  function automatic logic [RES_W-1:0] mag(input logic signed [RES_W-1:0] v);
    return v[RES_W-1] ? RES_W'(-v) : RES_W'(v);
  endfunction

  assign eng_sel  = (st != E_IDLE);
  assign eng_addr = idx;
  assign inner    = (idx != '0) && (idx != CODE_W'(NCODE - 1));
  assign res_we   = (st == E_BWRITE);

  arl_divider #(.NUM_W(NUM_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_go),
    .num  (div_num),
    .den  (div_den),
    .done (div_done),
    .quot (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st      <= E_IDLE;
      idx     <= '0;
      sum_q   <= '0;
      ideal_q <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
      dnl_cur <= '0;
      acc     <= '0;
      fin     <= 1'b0;
      max_dnl <= '0;
      max_inl <= '0;
    end else begin
      div_go <= 1'b0;
      fin    <= 1'b0;
      if (go) begin
        st      <= E_SUMA;
        idx     <= CODE_W'(1);
        sum_q   <= '0;
        acc     <= '0;
        max_dnl <= '0;
        max_inl <= '0;
      end else begin
        case (st)
          E_SUMA: st <= E_SUMD;
          E_SUMD: begin
            sum_q <= sum_q + SUM_W'(cnt_q);
            if (idx == CODE_W'(NINNER)) st <= E_IDIV;
            else begin
              idx <= idx + 1'b1;
              st  <= E_SUMA;
            end
          end
          E_IDIV: begin
            div_go  <= 1'b1;
            div_num <= NUM_W'(sum_q) << FRAC;
            div_den <= NUM_W'(NINNER);
            st      <= E_IWAIT;
          end
          E_IWAIT: if (div_done) begin
            ideal_q <= div_q;
            idx     <= '0;
            st      <= E_BADDR;
          end
          E_BADDR: st <= E_BDATA;
          E_BDATA: begin
            if (inner && (cnt_q != '0)) begin
              div_go  <= 1'b1;
              div_num <= NUM_W'(cnt_q) << (2 * FRAC);
              div_den <= ideal_q;
              st      <= E_BWAIT;
            end else begin
              dnl_cur <= inner ? NEG_ONE : '0;
              st      <= E_BWRITE;
            end
          end
          E_BWAIT: if (div_done) begin
            dnl_cur <= $signed(RES_W'(div_q)) - ONE_S;
            st      <= E_BWRITE;
          end
          E_BWRITE: begin
            acc <= acc + dnl_cur;
            if (inner && (mag(dnl_cur) > max_dnl)) max_dnl <= mag(dnl_cur);
            if (mag(acc) > max_inl) max_inl <= mag(acc);
            if (idx == CODE_W'(NCODE - 1)) begin
              fin <= 1'b1;
              st  <= E_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st  <= E_BADDR;
            end
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (res_we) res_mem[idx] <= {dnl_cur, acc};
    rq <= res_mem[usr_addr];
  end

  assign rd_dnl = rq[2*RES_W-1:RES_W];
  assign rd_inl = rq[RES_W-1:0];

  // R6: no code width can go below minus one LSB
  p_dnl_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (st == E_BWRITE) |-> (dnl_cur >= NEG_ONE));

  // R5: end codes are written with a zero width error
  p_end_dnl_r5: assert property (@(posedge clk) disable iff (rst)
    ((st == E_BWRITE) && !inner) |-> (dnl_cur == '0));

  // R8: maxima only grow while an analysis is running
  p_max_mono_r8: assert property (@(posedge clk) disable iff (rst)
    ((st != E_IDLE) && !go && !clr) |=>
      ((max_dnl >= $past(max_dnl)) && (max_inl >= $past(max_inl))));
endmodule

// File: rtl/adc_ramp_linearity.sv
module adc_ramp_linearity #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12,
  parameter int LEN_W  = 16,
  parameter int FRAC   = 8,
  localparam int NUM_A = CNT_W + 2 * FRAC,
  localparam int NUM_B = CNT_W + CODE_W + FRAC,
  localparam int NUM_W = (NUM_A > NUM_B) ? NUM_A : NUM_B,
  localparam int RES_W = NUM_W + CODE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    start,
  input  logic [LEN_W-1:0]        rec_len,
  input  logic                    smp_valid,
  input  logic [CODE_W-1:0]       smp_code,
  input  logic [CODE_W-1:0]       rd_addr,
  output logic [CNT_W-1:0]        rd_count,
  output logic signed [RES_W-1:0] rd_dnl,
  output logic signed [RES_W-1:0] rd_inl,
  output logic [RES_W-1:0]        max_dnl,
  output logic [RES_W-1:0]        max_inl,
  output logic                    overflow,
  output logic                    done
);
  import arl_pkg::*;

  ctl_state_t        state;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [1:0]        drain_q;
  logic              go_q, acc_v, clr_busy, eng_sel, fin;
  logic [CODE_W-1:0] eng_addr;

  assign acc_v = (state == T_CAP) && smp_valid && (cnt_q < len_q);
  assign done  = (state == T_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= T_CLR;
      cnt_q   <= '0;
      len_q   <= '0;
      drain_q <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (clear) begin
        state <= T_CLR;
      end else begin
        case (state)
          T_CLR:  if (!clr_busy) state <= T_IDLE;
          T_IDLE: if (start) begin
            len_q <= rec_len;
            cnt_q <= '0;
            state <= T_CAP;
          end
          T_CAP: begin
            if (acc_v) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == len_q) begin
              drain_q <= '0;
              state   <= T_DRAIN;
            end
          end
          T_DRAIN: begin
            drain_q <= drain_q + 1'b1;
            if (drain_q == 2'd2) begin
              go_q  <= 1'b1;
              state <= T_ANA;
            end
          end
          T_ANA:  if (fin) state <= T_DONE;
          T_DONE: state <= T_DONE;
          default: state <= T_CLR;
        endcase
      end
    end
  end

  arl_bin_store #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
    .clk     (clk),
    .rst     (rst),
    .clr_req (clear),
    .clr_busy(clr_busy),
    .acc_v   (acc_v),
    .acc_code(smp_code),
    .eng_sel (eng_sel),
    .eng_addr(eng_addr),
    .usr_addr(rd_addr),
    .q       (rd_count),
    .ovf     (overflow)
  );

  arl_engine #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC(FRAC)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .clr     (clear),
    .go      (go_q),
    .cnt_q   (rd_count),
    .eng_sel (eng_sel),
    .eng_addr(eng_addr),
    .fin     (fin),
    .usr_addr(rd_addr),
    .rd_dnl  (rd_dnl),
    .rd_inl  (rd_inl),
    .max_dnl (max_dnl),
    .max_inl (max_inl)
  );

  // R9: the completion flag falls only on a clear
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> done);

  // R2: the record counter never passes the latched length
  p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (state == T_CAP) |-> (cnt_q <= len_q));
endmodule

// File: tb/adc_ramp_linearity_test.sv
module adc_ramp_linearity_test;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 12;
  localparam int LEN_W  = 16;
  localparam int FRAC   = 8;
  localparam int NCODE  = 1 << CODE_W;
  localparam int NUM_A  = CNT_W + 2 * FRAC;
  localparam int NUM_B  = CNT_W + CODE_W + FRAC;
  localparam int NUM_W  = (NUM_A > NUM_B) ? NUM_A : NUM_B;
  localparam int RES_W  = NUM_W + CODE_W + 1;
  localparam longint ONE = 1 << FRAC;
  localparam longint CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1, clear = 1'b0, start = 1'b0, smp_valid = 1'b0;
  logic [LEN_W-1:0]        rec_len = '0;
  logic [CODE_W-1:0]       smp_code = '0, rd_addr = '0;
  logic [CNT_W-1:0]        rd_count;
  logic signed [RES_W-1:0] rd_dnl, rd_inl;
  logic [RES_W-1:0]        max_dnl, max_inl;
  logic                    overflow, done;

  always #4 clk = ~clk;

  adc_ramp_linearity #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .FRAC(FRAC)) uut (
    .clk(clk), .rst(rst), .clear(clear), .start(start), .rec_len(rec_len),
    .smp_valid(smp_valid), .smp_code(smp_code), .rd_addr(rd_addr),
    .rd_count(rd_count), .rd_dnl(rd_dnl), .rd_inl(rd_inl),
    .max_dnl(max_dnl), .max_inl(max_inl), .overflow(overflow), .done(done)
  );

  typedef struct {
    int     code;
    longint cnt;
    longint dnl;
    longint inl;
    bit     res;
    string  tag;
  } item_t;

  item_t  sbq[$];
  item_t  mon_it;
  int     n_chk = 0, n_fail = 0;
  longint eh[NCODE];
  longint exp_dnl[NCODE], exp_inl[NCODE];
  longint exp_maxd, exp_maxi;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each read result one edge after its address
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      mon_it = sbq.pop_front();
      check(longint'(rd_count) == mon_it.cnt, $sformatf("%s count code %0d", mon_it.tag, mon_it.code),
            longint'(rd_count), mon_it.cnt);
      if (mon_it.res) begin
        check(longint'(rd_dnl) == mon_it.dnl, $sformatf("%s dnl code %0d", mon_it.tag, mon_it.code),
              longint'(rd_dnl), mon_it.dnl);
        check(longint'(rd_inl) == mon_it.inl, $sformatf("%s inl code %0d", mon_it.tag, mon_it.code),
              longint'(rd_inl), mon_it.inl);
      end
    end
  end

  // driver: issues the addresses and queues what must come back
  task automatic read_all(input string tag, input bit res);
    for (int k = 0; k < NCODE; k++) begin
      @(negedge clk);
      rd_addr = CODE_W'(k);
      sbq.push_back('{k, eh[k], exp_dnl[k], exp_inl[k], res, tag});
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int code);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = CODE_W'(code);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    smp_valid = 1'b0;
    rec_len = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    smp_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int w = 0;
    while (!done && w < 30000) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, {tag, " done within bound"}, longint'(done), 1);
  endtask

  task automatic zero_model();
    for (int k = 0; k < NCODE; k++) begin
      eh[k] = 0;
      exp_dnl[k] = 0;
      exp_inl[k] = 0;
    end
    exp_maxd = 0;
    exp_maxi = 0;
  endtask

  // R4..R8 computed from the written rules
  task automatic compute();
    longint sum, ideal, acc, d, a;
    sum = 0;
    acc = 0;
    exp_maxd = 0;
    exp_maxi = 0;
    for (int k = 1; k < NCODE - 1; k++) sum += eh[k];
    ideal = (sum * ONE) / (NCODE - 2);
    for (int k = 0; k < NCODE; k++) begin
      if (k == 0 || k == NCODE - 1) d = 0;
      else if (eh[k] == 0)          d = -ONE;
      else                          d = (eh[k] * ONE * ONE) / ideal - ONE;
      exp_dnl[k] = d;
      exp_inl[k] = acc;
      a = (acc < 0) ? -acc : acc;
      if (a > exp_maxi) exp_maxi = a;
      a = (d < 0) ? -d : d;
      if (k != 0 && k != NCODE - 1 && a > exp_maxd) exp_maxd = a;
      acc += d;
    end
  endtask

  task automatic check_max(input string tag);
    check(longint'(max_dnl) == exp_maxd, {tag, " max_dnl"}, longint'(max_dnl), exp_maxd);
    check(longint'(max_inl) == exp_maxi, {tag, " max_inl"}, longint'(max_inl), exp_maxi);
  endtask

  initial begin
    int counts[NCODE];
    int total;
    zero_model();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);

    // R11: reset state
    check(done == 1'b0, "R11 done after reset", longint'(done), 0);
    check(overflow == 1'b0, "R11 overflow after reset", longint'(overflow), 0);
    check_max("R11");
    read_all("R11", 1'b0);

    // R1, R2: uniform ramp with stray samples before and after the record
    for (int i = 0; i < 5; i++) send(7);
    quiet(2);
    pulse_start(8 * NCODE);
    for (int k = 0; k < NCODE; k++)
      for (int j = 0; j < 8; j++) begin
        send(k);
        eh[k]++;
      end
    for (int i = 0; i < 6; i++) send(3);
    quiet(1);
    wait_done("R9 uniform");
    compute();
    check(overflow == 1'b0, "R3 no overflow on uniform ramp", longint'(overflow), 0);
    check_max("R8 uniform");
    read_all("R1 R2 R5 R7 uniform", 1'b1);

    // R9: start and samples while done change nothing
    pulse_start(4);
    for (int i = 0; i < 4; i++) send(9);
    quiet(3);
    check(done == 1'b1, "R9 done holds after start", longint'(done), 1);
    read_all("R9 ignored while done", 1'b1);

    // R10: clear
    pulse_clear();
    check(done == 1'b0, "R10 done drops on clear", longint'(done), 0);
    check_max("R10 after clear");
    zero_model();
    repeat (NCODE + 6) @(negedge clk);
    read_all("R10 zeroed", 1'b0);

    // R4..R8: uneven ramp with gaps and two missing codes
    counts = '{3, 9, 7, 8, 0, 12, 8, 5, 8, 10, 8, 0, 6, 9, 7, 2};
    total = 0;
    for (int k = 0; k < NCODE; k++) total += counts[k];
    pulse_start(total);
    for (int k = 0; k < NCODE; k++)
      for (int j = 0; j < counts[k]; j++) begin
        send(k);
        eh[k]++;
        if ((j % 3) == 2) quiet(1);
      end
    quiet(1);
    wait_done("R9 uneven");
    compute();
    check_max("R8 uneven");
    read_all("R4 R5 R6 R7 uneven", 1'b1);

    // R3: one code driven past saturation
    pulse_clear();
    zero_model();
    repeat (NCODE + 6) @(negedge clk);
    pulse_start(4100 + 3);
    for (int i = 0; i < 4100; i++) send(5);
    for (int i = 0; i < 3; i++) send(0);
    quiet(1);
    eh[5] = (4100 > CMAX) ? CMAX : 4100;
    eh[0] = 3;
    wait_done("R9 saturation");
    compute();
    check(overflow == 1'b1, "R3 overflow set", longint'(overflow), 1);
    check_max("R8 saturation");
    read_all("R3 R6 saturation", 1'b1);
    pulse_clear();
    check(overflow == 1'b0, "R10 overflow cleared", longint'(overflow), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule